// File: doc/BRIEF.md
# Paged Flash Sector Programmer

This controller sits on the system side of an external byte-wide paged flash. It writes one full 64-byte sector per command. The host supplies a sector number and a start pulse. The controller then fetches each byte through a local buffer port: it presents a byte index and takes the byte back in the same cycle. It drives the flash chip enable, output enable, write enable, address and data lines directly.

A program operation has three phases. First come three protection-unlock writes. Next, all 64 sector bytes are loaded in ascending index order, each load separated from the next by a gap shorter than the flash's load timeout. Last, the controller polls the final loaded address until bit 7 of the read value matches bit 7 of the byte it wrote. While the flash is busy it returns the complement of that bit.

On success the controller pulses a done flag. If polling runs longer than a set number of cycles, it raises an error flag and goes back to idle. All strobe widths are given in clock cycles through parameters.

Top module: `sector_prog_ctrl`

## Requirements
- R1: After reset the controller is idle: busy_o, done_o and err_o are low, the three flash strobes are high, and the data bus is not driven.
- R2: Every operation begins with three writes, in this order: data AAh to address 5555h, then 55h to 2AAAh, then A0h to 5555h.
- R3: After the unlock writes, all 64 bytes are written. Byte index i (0 to 63) goes to address {sector, i[5:0]}, with the sector in address bits 14:6. Its data is the buffer byte returned for buf_addr_o = i.
- R4: Each write-enable low pulse lasts at least WP_CYC cycles. Each high time between consecutive writes of one operation lasts at least WPH_CYC and fewer than BLC_CYC cycles.
- R5: Whenever write enable is low, output enable is high and the data bus is driven. Address and write data do not change while write enable stays low.
- R6: After the last load, the controller releases the data bus and reads address {sector, 3Fh} with output enable low and write enable high. It reports completion only once a read returns bit 7 equal to bit 7 of the last loaded byte.
- R7: done_o is a single-cycle pulse, and busy_o is already low in that cycle.
- R8: If polling lasts POLL_MAX cycles without a match, err_o rises and the controller returns to idle without a done pulse. err_o stays high until the next accepted start.
- R9: A start pulse while busy_o is high is ignored. The running operation completes on its original sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| sector_i | input | 9 | Sector number to program |
| buf_addr_o | output | 6 | Byte index requested from the local buffer |
| buf_data_i | input | 8 | Buffer byte for buf_addr_o, same cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | Polling timeout flag |
| flash_addr_o | output | 15 | Flash address |
| flash_dq_o | output | 8 | Flash write data |
| flash_dq_oe_o | output | 1 | Drive enable for flash data |
| flash_dq_i | input | 8 | Flash read data |
| flash_ce_no | output | 1 | Flash chip enable, active low |
| flash_oe_no | output | 1 | Flash output enable, active low |
| flash_we_no | output | 1 | Flash write enable, active low |

## Verification
The bench builds the controller with WP_CYC=3, WPH_CYC=2, BLC_CYC=8, RD_CYC=2 and POLL_MAX=400. These short strobes keep a full 67-write operation near 340 cycles, so many random sectors and buffer patterns fit in the run. A behavioural flash model checks unlock order, strobe widths, the load gap and the poll address. The model's busy time can be set per operation, from one cycle up to a value that never ends. This means an early done, a zero-length busy time and the polling timeout can all be reached within a 400-cycle limit.

// File: rtl/spc_pkg.sv
package spc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLO,
    ST_WHI,
    ST_RD,
    ST_RGAP
  } spc_state_e;

  localparam int UNLOCK_LEN = 3;

  function automatic logic [14:0] unlock_addr(input logic [1:0] step);
    return (step == 2'd1) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [7:0] unlock_data(input logic [1:0] step);
    case (step)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction
endpackage

// File: rtl/spc_timer.sv
module spc_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/spc_poll_cnt.sv
module spc_poll_cnt #(
  parameter int LIMIT = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl
  import spc_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int PAGE_W   = 6,
  parameter int DATA_W   = 8,
  parameter int WP_CYC   = 3,
  parameter int WPH_CYC  = 2,
  parameter int BLC_CYC  = 8,
  parameter int RD_CYC   = 2,
  parameter int POLL_MAX = 400
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [ADDR_W-PAGE_W-1:0]   sector_i,
  output logic [PAGE_W-1:0]          buf_addr_o,
  input  logic [DATA_W-1:0]          buf_data_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       err_o,
  output logic [ADDR_W-1:0]          flash_addr_o,
  output logic [DATA_W-1:0]          flash_dq_o,
  output logic                       flash_dq_oe_o,
  input  logic [DATA_W-1:0]          flash_dq_i,
  output logic                       flash_ce_no,
  output logic                       flash_oe_no,
  output logic                       flash_we_no
);
  localparam int SECT_W   = ADDR_W - PAGE_W;
  localparam int PAGE_SZ  = 1 << PAGE_W;
  localparam int LAST_IDX = UNLOCK_LEN + PAGE_SZ - 1;
  localparam int IDX_W    = $clog2(LAST_IDX + 1);
  localparam int TMAX     = (WP_CYC > WPH_CYC) ? ((WP_CYC > RD_CYC) ? WP_CYC : RD_CYC)
                                               : ((WPH_CYC > RD_CYC) ? WPH_CYC : RD_CYC);
  localparam int TMR_W    = $clog2(TMAX + 1);

  spc_state_e         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [SECT_W-1:0]  sector_q;
  logic               last_bit_q, last_bit_d;
  logic               done_q, done_d, err_q, err_d;
  logic               tmr_load, tmr_exp, poll_hit;
  logic [TMR_W-1:0]   tmr_val;
  logic               in_unlock;
  logic [PAGE_W-1:0]  page_off;
  logic [DATA_W-1:0]  wr_data;
  logic [ADDR_W-1:0]  wr_addr;

  spc_timer #(.W(TMR_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_exp)
  );

  spc_poll_cnt #(.LIMIT(POLL_MAX)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_WHI),
    .en_i   ((state_q == ST_RD) || (state_q == ST_RGAP)),
    .hit_o  (poll_hit)
  );

  assign in_unlock = (idx_q < IDX_W'(UNLOCK_LEN));
  assign page_off  = in_unlock ? '0 : PAGE_W'(idx_q - IDX_W'(UNLOCK_LEN));
  assign wr_data   = in_unlock ? DATA_W'(unlock_data(idx_q[1:0])) : buf_data_i;
  assign wr_addr   = in_unlock ? ADDR_W'(unlock_addr(idx_q[1:0])) : {sector_q, page_off};

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    last_bit_d = last_bit_q;
    done_d     = 1'b0;
    err_d      = err_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_WLO;
        idx_d    = '0;
        err_d    = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(WP_CYC - 1);
      end
      ST_WLO: if (tmr_exp) begin
        state_d  = ST_WHI;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(WPH_CYC - 1);
        if (idx_q == IDX_W'(LAST_IDX)) last_bit_d = wr_data[DATA_W-1];
      end
      ST_WHI: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (idx_q == IDX_W'(LAST_IDX)) begin
          state_d = ST_RD;
          tmr_val = TMR_W'(RD_CYC - 1);
        end else begin
          state_d = ST_WLO;
          idx_d   = idx_q + 1'b1;
          tmr_val = TMR_W'(WP_CYC - 1);
        end
      end
      ST_RD: begin
        if (poll_hit) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if (tmr_exp) begin
          if (flash_dq_i[DATA_W-1] == last_bit_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d  = ST_RGAP;
          end
        end
      end
      ST_RGAP: begin
        // one cycle with output enable high between polls
        if (poll_hit) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else begin
          state_d  = ST_RD;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(RD_CYC - 1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      sector_q   <= '0;
      last_bit_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      last_bit_q <= last_bit_d;
      done_q     <= done_d;
      err_q      <= err_d;
      if (state_q == ST_IDLE && start_i) sector_q <= sector_i;
    end
  end

  wire is_write = (state_q == ST_WLO) || (state_q == ST_WHI);
  wire is_poll  = (state_q == ST_RD) || (state_q == ST_RGAP);

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign buf_addr_o    = page_off;
  assign flash_ce_no   = (state_q == ST_IDLE);
  assign flash_we_no   = (state_q != ST_WLO);
  assign flash_oe_no   = (state_q != ST_RD);
  assign flash_dq_oe_o = is_write;
  assign flash_dq_o    = is_write ? wr_data : '0;
  assign flash_addr_o  = is_write ? wr_addr
                       : is_poll  ? {sector_q, {PAGE_W{1'b1}}} : '0;
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int WP_CYC  = 3,
  parameter int WPH_CYC = 2,
  parameter int BLC_CYC = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic [DATA_W-1:0] flash_dq_o,
  input logic              flash_dq_oe_o,
  input logic              flash_ce_no,
  input logic              flash_oe_no,
  input logic              flash_we_no
);
  logic [15:0] lo_cnt, hi_cnt;
  logic        seen_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt  <= '0;
      hi_cnt  <= '0;
      seen_wr <= 1'b0;
    end else begin
      lo_cnt  <= flash_we_no ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt  <= !flash_we_no ? 16'd0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1);
      if (flash_ce_no)       seen_wr <= 1'b0;
      else if (!flash_we_no) seen_wr <= 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (flash_ce_no && flash_we_no && flash_oe_no && !flash_dq_oe_o));

  p_wp_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flash_we_no) |-> (lo_cnt >= 16'(WP_CYC)));

  p_gap_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(flash_we_no) && seen_wr) |-> (hi_cnt >= 16'(WPH_CYC) && hi_cnt < 16'(BLC_CYC)));

  p_oe_high_on_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_no |-> (flash_oe_no && flash_dq_oe_o && !flash_ce_no));

  p_stable_on_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no && $past(!flash_we_no)) |-> ($stable(flash_addr_o) && $stable(flash_dq_o)));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !err_o) ##1 !done_o);

  p_err_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o);
endmodule

bind sector_prog_ctrl spc_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WP_CYC (WP_CYC),
  .WPH_CYC(WPH_CYC),
  .BLC_CYC(BLC_CYC)
) u_spc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .flash_addr_o (flash_addr_o),
  .flash_dq_o   (flash_dq_o),
  .flash_dq_oe_o(flash_dq_oe_o),
  .flash_ce_no  (flash_ce_no),
  .flash_oe_no  (flash_oe_no),
  .flash_we_no  (flash_we_no)
);

// File: tb/sector_prog_ctrl_tb.sv
module sector_prog_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WP = 3, WPH = 2, BLC = 8, RDC = 2, PMAX = 400;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [8:0]  sector = '0;
  logic [5:0]  buf_addr;
  logic [7:0]  buf_data, dq_o, dq_i;
  logic [14:0] addr;
  logic busy, done, err, dq_oe, ce_n, oe_n, we_n;
  logic [7:0] bbuf [64];

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign buf_data = bbuf[buf_addr];

  sector_prog_ctrl #(.WP_CYC(WP), .WPH_CYC(WPH), .BLC_CYC(BLC), .RD_CYC(RDC), .POLL_MAX(PMAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sector_i(sector),
    .buf_addr_o(buf_addr), .buf_data_i(buf_data), .busy_o(busy), .done_o(done), .err_o(err),
    .flash_addr_o(addr), .flash_dq_o(dq_o), .flash_dq_oe_o(dq_oe), .flash_dq_i(dq_i),
    .flash_ce_no(ce_n), .flash_oe_no(oe_n), .flash_we_no(we_n));

  // behavioural flash model
  logic [7:0]  m_mem [64];
  logic [8:0]  m_tag;
  logic [14:0] m_cap, m_last_addr;
  logic [7:0]  m_last;
  logic        m_we_q = 1'b1, m_stuck = 1'b0, m_polled = 1'b0;
  int m_prog = 0, m_prog_len = 10, m_wr = 0, m_lo = 0, m_hi = 0;
  int m_unlock_bad = 0, m_wp_bad = 0, m_gap_bad = 0, m_oe_bad = 0, m_rd_bad = 0, m_tag_bad = 0;

  assign dq_i = (m_prog > 0 || m_stuck) ? {~m_last[7], 7'h15}
              : ((addr[14:6] == m_tag) ? m_mem[addr[5:0]] : 8'hFF);

  function automatic logic [14:0] exp_uaddr(input int i);
    return (i == 1) ? 15'h2AAA : 15'h5555;
  endfunction
  function automatic logic [7:0] exp_udata(input int i);
    return (i == 0) ? 8'hAA : (i == 1) ? 8'h55 : 8'hA0;
  endfunction

  always @(negedge clk) begin
    if (m_prog > 0) m_prog--;
    if (!busy) m_wr = 0;
    if (!ce_n && !we_n && !oe_n) m_oe_bad++;
    if (!ce_n && m_we_q && !we_n) begin
      m_cap = addr;
      if (m_wr > 0 && (m_hi < WPH || m_hi >= BLC)) m_gap_bad++;
      m_lo = 0;
    end
    if (!ce_n && !m_we_q && we_n) begin
      if (m_lo < WP) m_wp_bad++;
      if (m_wr < 3) begin
        if (m_cap != exp_uaddr(m_wr) || dq_o != exp_udata(m_wr)) m_unlock_bad++;
        if (m_wr == 0) begin
          for (int i = 0; i < 64; i++) m_mem[i] = 8'hFF;
          m_tag = '1;
        end
      end else if (m_wr < 67) begin
        if (m_wr == 3) m_tag = m_cap[14:6];
        else if (m_tag != m_cap[14:6]) m_tag_bad++;
        m_mem[m_cap[5:0]] = dq_o;
        if (m_wr == 66) begin
          m_last = dq_o; m_last_addr = m_cap; m_prog = m_prog_len; m_polled = 1'b0;
        end
      end
      m_wr++;
      m_hi = 0;
    end
    if (!we_n) m_lo++; else m_hi++;
    if (!ce_n && !oe_n) begin
      if (addr != m_last_addr || dq_oe) m_rd_bad++;
      if (m_prog > 0 || m_stuck) m_polled = 1'b1;
    end
    m_we_q = we_n;
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic run_op(input logic [8:0] sec, input int prog, input bit stuck, input bit poke,
                        output bit got_done, output bit got_err);
    int n = 0;
    m_prog_len = prog; m_stuck = stuck;
    sector = sec; start = 1'b1; tick(); start = 1'b0;
    check(busy && !err, "R8", {busy, err}, 2'b10);
    while (!done && !err && n < 2000) begin
      if (poke && n == 40) begin sector = ~sec; start = 1'b1; end
      else start = 1'b0;
      tick(); n++;
    end
    start = 1'b0;
    got_done = done; got_err = err;
  endtask

  task automatic check_page(input logic [8:0] sec);
    int bad = 0;
    for (int i = 0; i < 64; i++) if (m_mem[i] != bbuf[i]) bad++;
    check(bad == 0 && m_tag == sec && m_tag_bad == 0, "R3", m_tag, sec);
    check(m_unlock_bad == 0, "R2", m_unlock_bad, 0);
    check(m_wp_bad == 0 && m_gap_bad == 0, "R4", m_wp_bad + m_gap_bad, 0);
    check(m_oe_bad == 0, "R5", m_oe_bad, 0);
    check(m_rd_bad == 0, "R6", m_rd_bad, 0);
  endtask

  task automatic normal(input logic [8:0] sec, input int prog, input bit poke);
    bit d, e;
    run_op(sec, prog, 1'b0, poke, d, e);
    check(d && !e, "R6", {d, e}, 2'b10);
    check(m_prog == 0, "R6", m_prog, 0);
    if (prog > RDC + 1) check(m_polled, "R6", m_polled, 1);
    check(!busy, "R7", busy, 0);
    tick();
    check(!done, "R7", done, 1'b0);
    check_page(sec);
    if (poke) begin
      for (int i = 0; i < 20; i++) tick();
      check(!busy && !done, "R9", busy, 0);
    end
  endtask

  initial begin
    bit d, e;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) bbuf[i] = 8'h00;
    tick(); tick();
    check(!busy && !done && !err && ce_n && oe_n && we_n && !dq_oe, "R1",
          {busy, done, err, ce_n, oe_n, we_n, dq_oe}, 7'b0001110);
    rst_n = 1'b1; tick();
    check(ce_n && !busy, "R1", ce_n, 1);
    // directed: all zero buffer, sector 0, short busy
    normal(9'd0, 1, 1'b0);
    for (int i = 0; i < 64; i++) bbuf[i] = 8'hFF;
    normal(9'h1FF, 120, 1'b0);
    // start while busy is ignored
    for (int i = 0; i < 64; i++) bbuf[i] = 8'($urandom);
    normal(9'h0A5, 60, 1'b1);
    // polling timeout
    run_op(9'h033, 0, 1'b1, 1'b0, d, e);
    check(e && !d, "R8", {d, e}, 2'b01);
    check(!busy, "R8", busy, 0);
    m_stuck = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    check(err, "R8", err, 1);
    // random runs
    for (int r = 0; r < 10; r++) begin
      for (int i = 0; i < 64; i++) bbuf[i] = 8'($urandom);
      normal(9'($urandom), 1 + int'($urandom % 250), 1'b0);
      check(!err, "R8", err, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    checks++; fails++;
    $display("FAIL watchdog R1 actual=%0d expected=<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule